// File: doc/BRIEF.md
# DDR2 Burst Column Address Sequencer

This block turns one burst request into the ordered list of column addresses that a DDR2 read or write burst visits. The request carries a starting column, a burst length code and a wrap-order selector. The block takes it on a single-cycle start strobe and then emits one column address per data beat, with a valid flag and a flag on the final beat. A memory controller uses the sequence to index its write data or to tag returning read data.

Only the low column bits that address a position inside the aligned block of 2, 4 or 8 elements are sequenced. The column bits above that block come from the starting column and stay unchanged. Two wrap orders are available. The sequential order adds the beat number to the starting position. For length 8 it counts modulo four inside the current half-block, then flips to the other half. The interleaved order XORs the beat number into the starting position. The block never steps into a neighbouring block.

Top module: `ddr2_burst_colseq`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `valid_o`, `last_o` and `busy_o` are low.
- R2: A start strobe sampled while no burst is running is accepted. On the next cycle `valid_o` and `busy_o` are high and `col_o` equals the starting column. Further beats follow on consecutive cycles.
- R3: On every beat of a burst, the column bits above the aligned block (above bit 0 for length 2, above bit 1 for length 4, above bit 2 for length 8) equal those of the starting column.
- R4: Sequential order with length 2 or 4: the in-block offset on beat b is (s + b) mod BL, where s is the starting offset.
- R5: Sequential order with length 8: bits 1:0 of the offset on beat b are (s[1:0] + b) mod 4. Bit 2 equals s[2] on beats 0 to 3 and its inverse on beats 4 to 7.
- R6: Interleaved order, any length: the in-block offset on beat b is s XOR b.
- R7: `burst_len_i` encodes the length: 2'b00 is 2 beats, 2'b01 is 4, 2'b10 is 8, and 2'b11 also gives 8. `burst_type_i` = 0 selects sequential order and 1 selects interleaved order.
- R8: `last_o` is high only on beat BL-1, and `valid_o` is low on the cycle after that beat.
- R9: The starting column, length and type are captured on the accepted strobe. Changes to those inputs during a burst do not affect the addresses emitted.
- R10: `busy_o` is high on every beat. A start strobe sampled during a burst, including on its last beat, is ignored: the running sequence continues unchanged, and no burst follows the last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Burst request strobe |
| start_col_i | input | COL_W | Starting column address |
| burst_len_i | input | 2 | Length code (see R7) |
| burst_type_i | input | 1 | 0 sequential, 1 interleaved |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Current beat is the final one |
| busy_o | output | 1 | A burst is in progress |

## Verification
The assertions check the following on every cycle:
- the beat counter steps by one between consecutive beats;
- `valid_o` falls right after `last_o`;
- the upper column bits hold for the whole burst;
- the first beat repeats the starting column;
- the captured length and type do not move mid-burst;
- a strobe during a burst leaves the captured column unchanged.

The per-beat wrap orders can only be shown by the bench scenarios. These cover every starting offset for every length code and type, plus random bursts, all compared against an independent model. The same scenarios also show that a strobe or changed inputs during a burst do not alter the emitted addresses.

// File: rtl/ddr2_bcs_pkg.sv
package ddr2_bcs_pkg;

  // widest aligned block: 8 elements
  localparam int BLK_W = 3;

  typedef enum logic {
    BT_SEQ = 1'b0,
    BT_ILV = 1'b1
  } btype_e;

  typedef enum logic [1:0] {
    BLC_2  = 2'd0,
    BLC_4  = 2'd1,
    BLC_8  = 2'd2,
    BLC_8R = 2'd3
  } blen_e;

  // bits of the in-block offset that the length code lets move
  function automatic logic [BLK_W-1:0] blk_mask(blen_e len);
    case (len)
      BLC_2:   blk_mask = 3'b001;
      BLC_4:   blk_mask = 3'b011;
      default: blk_mask = 3'b111;
    endcase
  endfunction

  function automatic logic [BLK_W-1:0] final_beat(blen_e len);
    case (len)
      BLC_2:   final_beat = 3'd1;
      BLC_4:   final_beat = 3'd3;
      default: final_beat = 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/bcs_beat_ctrl.sv
module bcs_beat_ctrl
  import ddr2_bcs_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  blen_e            len_i,
  input  btype_e           type_i,
  output logic             active_o,
  output logic             last_o,
  output logic [BLK_W-1:0] beat_o,
  output logic [COL_W-1:0] base_o,
  output blen_e            len_o,
  output btype_e           type_o
);

  logic             active_q, active_d;
  logic [BLK_W-1:0] beat_q, beat_d;
  logic [COL_W-1:0] base_q;
  blen_e            len_q;
  btype_e           type_q;
  logic             accept;
  logic             at_end;

  assign accept = start_i & ~active_q;
  assign at_end = active_q & (beat_q == final_beat(len_q));

  // next state
  always_comb begin
    active_d = active_q;
    beat_d   = beat_q;
    if (accept) begin
      active_d = 1'b1;
      beat_d   = '0;
    end else if (active_q) begin
      if (at_end) begin
        active_d = 1'b0;
        beat_d   = '0;
      end else begin
        beat_d = beat_q + 1'b1;
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
    end else begin
      active_q <= active_d;
      beat_q   <= beat_d;
    end
  end

  // request capture, enabled by accept only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= BLC_2;
      type_q <= BT_SEQ;
    end else if (accept) begin
      base_q <= col_i;
      len_q  <= len_i;
      type_q <= type_i;
    end
  end

  assign active_o = active_q;
  assign last_o   = at_end;
  assign beat_o   = beat_q;
  assign base_o   = base_q;
  assign len_o    = len_q;
  assign type_o   = type_q;

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !at_end) |=> (active_q && beat_q == $past(beat_q) + 1'b1)); // R2

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !at_end) |=> ($stable(len_q) && $stable(type_q))); // R9

  AST_STROBE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && active_q) |=> $stable(base_q)); // R10

endmodule

// File: rtl/bcs_offset_gen.sv
module bcs_offset_gen
  import ddr2_bcs_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [BLK_W-1:0] beat_i,
  input  blen_e            len_i,
  input  btype_e           type_i,
  output logic [COL_W-1:0] col_o
);

  logic [BLK_W-1:0] seq_off;
  logic [BLK_W-1:0] ilv_off;
  logic [BLK_W-1:0] off;
  logic [BLK_W-1:0] mask;

  always_comb begin
    // sequential: count mod 4 in low pair, half-block flips after beat 3
    seq_off[1:0] = base_i[1:0] + beat_i[1:0];
    seq_off[2]   = base_i[2] ^ beat_i[2];
    ilv_off      = base_i[BLK_W-1:0] ^ beat_i;
    off          = (type_i == BT_ILV) ? ilv_off : seq_off;
    mask         = blk_mask(len_i);
  end

  for (genvar i = 0; i < BLK_W; i++) begin : g_bit
    assign col_o[i] = mask[i] ? off[i] : base_i[i];
  end

  assign col_o[COL_W-1:BLK_W] = base_i[COL_W-1:BLK_W];

endmodule

// File: rtl/ddr2_burst_colseq.sv
module ddr2_burst_colseq
  import ddr2_bcs_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [1:0]       burst_len_i,
  input  logic             burst_type_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             busy_o
);

  logic             active;
  logic             at_end;
  logic [BLK_W-1:0] beat;
  logic [COL_W-1:0] base;
  blen_e            len_cur;
  btype_e           type_cur;

  bcs_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .col_i    (start_col_i),
    .len_i    (blen_e'(burst_len_i)),
    .type_i   (btype_e'(burst_type_i)),
    .active_o (active),
    .last_o   (at_end),
    .beat_o   (beat),
    .base_o   (base),
    .len_o    (len_cur),
    .type_o   (type_cur)
  );

  bcs_offset_gen #(.COL_W(COL_W)) u_off (
    .base_i (base),
    .beat_i (beat),
    .len_i  (len_cur),
    .type_i (type_cur),
    .col_o  (col_o)
  );

  assign valid_o = active;
  assign busy_o  = active;
  assign last_o  = at_end;

  AST_LAST_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> !valid_o); // R8

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o); // R8

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(valid_o)) |-> $stable(col_o[COL_W-1:BLK_W])); // R3

  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> (col_o == $past(start_col_i))); // R2

endmodule

// File: tb/ddr2_burst_colseq_tb.sv
module ddr2_burst_colseq_tb_top;

  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start_i;
  logic [COL_W-1:0] start_col_i;
  logic [1:0]       burst_len_i;
  logic             burst_type_i;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o, busy_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  ddr2_burst_colseq #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .burst_len_i(burst_len_i), .burst_type_i(burst_type_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .busy_o(busy_o)
  );

  function automatic int len_of(input logic [1:0] code);
    return (code == 2'd0) ? 2 : (code == 2'd1) ? 4 : 8;
  endfunction

  function automatic logic [COL_W-1:0] ref_col(input logic [COL_W-1:0] s,
                                               input logic [1:0] code,
                                               input logic t, input int b);
    int n, so, o;
    n  = len_of(code);
    so = int'(s) % n;
    if (t)          o = so ^ b;
    else if (n < 8) o = (so + b) % n;
    else            o = (((so / 4) ^ (b / 4)) * 4) + (((so % 4) + (b % 4)) % 4);
    return COL_W'(int'(s) - so + o);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one burst; disturb: change inputs and strobe mid-burst
  task automatic burst(input logic [COL_W-1:0] s, input logic [1:0] code,
                       input logic t, input bit disturb);
    int n;
    n = len_of(code);
    @(negedge clk);
    start_i = 1'b1; start_col_i = s; burst_len_i = code; burst_type_i = t;
    @(negedge clk);
    start_i = 1'b0;
    for (int b = 0; b < n; b++) begin
      string tag;
      tag = t ? "R6" : ((n == 8) ? "R5" : "R4");
      check("R2 valid", valid_o, 1'b1);
      check("R10 busy", busy_o, 1'b1);
      check(tag, col_o, ref_col(s, code, t, b));
      check("R3 upper", col_o >> 3, s >> 3);
      check("R8 last", last_o, (b == n - 1));
      if (disturb) begin
        // R9 R10: new inputs and strobe while running
        start_i      = 1'b1;
        start_col_i  = COL_W'($urandom);
        burst_len_i  = 2'($urandom);
        burst_type_i = 1'($urandom);
      end
      if (b == n - 1) start_i = 1'b1; // R10 strobe on last beat ignored
      @(negedge clk);
    end
    start_i = 1'b0;
    check("R8 valid drop", valid_o, 1'b0);
    check("R10 no follow", busy_o, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; start_col_i = '0;
    burst_len_i = '0; burst_type_i = 1'b0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R1 valid", valid_o, 1'b0);
    check("R1 last", last_o, 1'b0);
    check("R1 busy", busy_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {valid_o, last_o, busy_o}, 3'b000);

    // directed examples
    burst(10'h3F1, 2'd2, 1'b0, 0); // R5 start 1: 1-2-3-0-5-6-7-4
    burst(10'h0A6, 2'd2, 1'b0, 0); // R5 start 6
    burst(10'h125, 2'd2, 1'b1, 0); // R6 start 5
    burst(10'h2B3, 2'd1, 1'b0, 0); // R4 start 3
    burst(10'h2B3, 2'd3, 1'b1, 0); // R7 reserved code acts as 8

    // R7: every offset, every length code, every type
    for (int c = 0; c < 4; c++)
      for (int t = 0; t < 2; t++)
        for (int o = 0; o < 8; o++)
          burst(COL_W'(($urandom << 3) | o), 2'(c), 1'(t), 0);

    // random mix with mid-burst disturbance (R9, R10)
    for (int k = 0; k < 150; k++)
      burst(COL_W'($urandom), 2'($urandom), 1'($urandom), ($urandom % 2) == 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule